// File: doc/BRIEF.md
# Atomic Reservation Monitor for a Shared Word Memory

This block sits in front of a small word memory that is shared by two requesters, and makes read-modify-write sequences atomic. A requester opens a sequence with a linked read. The linked read returns the word like a plain read and also records a reservation on that word address for that requester. The requester closes the sequence with a conditional store. The conditional store writes only when the reservation is still intact. It reports success (1) or failure (0) on the response flag.

Each requester has a request channel with a valid/ready handshake and a response channel that is valid for one cycle. Only one operation is executed per cycle, because the memory has one port. A two-state arbiter picks the requester to serve. `ARB_OPEN` favours requester 0; when both requesters ask at once it moves to `ARB_OWED1`. `ARB_OWED1` favours requester 1 for one cycle and always returns to `ARB_OPEN`.

Operation codes on each 2-bit op field are: 0 = plain read, 1 = plain write, 2 = linked read, 3 = conditional store.

Top module: `llsc_monitor`

## Requirements
- R1: After reset, every memory word reads as zero, no reservation exists, no response is valid, and both ready outputs are high while no request is pending.
- R2: A plain read (op 0) or linked read (op 2) that is accepted on a clock edge yields, in the following cycle, a one-cycle response on that requester's channel carrying the stored word and flag 0.
- R3: An accepted plain write (op 1) stores its data at the address and yields a response with flag 0 in the following cycle.
- R4: A conditional store (op 3) whose requester holds a reservation on the same address stores its data and returns flag 1.
- R5: A conditional store without a reservation, or with a reservation on another address, returns flag 0 and leaves memory unchanged.
- R6: A write by the other requester to a reserved address cancels that reservation, so the later conditional store fails.
- R7: Writes to other addresses leave a reservation intact.
- R8: A conditional store removes its own requester's reservation whether it succeeds or fails, so a second conditional store without a new linked read fails.
- R9: A successful conditional store cancels the other requester's reservation on the same address.
- R10: A new linked read replaces the requester's earlier reservation; only the newest address can succeed.
- R11: When both requesters are valid in `ARB_OPEN`, requester 0 is accepted and requester 1 sees ready low for exactly one cycle. In the next cycle (`ARB_OWED1`) requester 1 is accepted and ready for requester 0 is low if requester 0 is valid. At most one request is accepted per cycle.
- R12: A requester's own plain write to its reserved address also cancels its reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_vld_i | input | 2 | Request valid, bit k for requester k |
| req_rdy_o | output | 2 | Request accepted on the edge where valid and ready are both high |
| req_op_i | input | 4 | Op code, bits [2k+1:2k] for requester k |
| req_addr_i | input | 2*AW | Word address per requester |
| req_wdata_i | input | 2*DW | Write data per requester |
| rsp_vld_o | output | 2 | Response valid, one cycle after acceptance |
| rsp_data_o | output | 2*DW | Read data per requester (zero for writes and conditional stores) |
| rsp_flag_o | output | 2 | Conditional store outcome, 1 = stored |

## Verification
The properties assume that a requester keeps valid high, with its op, address and data stable, until ready is seen high. Under that assumption, a stalled requester is accepted on the very next edge. The bench drives every request through one task that holds the request fields from a falling edge until the accepting rising edge. It drives the same-cycle contention case by hand under the same hold discipline. All addresses used lie inside the memory depth.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
    localparam int NREQ = 2;

    typedef enum logic [1:0] {
        OP_RD = 2'd0,
        OP_WR = 2'd1,
        OP_LL = 2'd2,
        OP_SC = 2'd3
    } op_e;

    typedef enum logic {
        ARB_OPEN  = 1'b0,
        ARB_OWED1 = 1'b1
    } arb_e;
endpackage

// File: rtl/llsc_arbiter.sv
module llsc_arbiter
    import llsc_pkg::*;
(
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [NREQ-1:0] vld_i,
    output logic [NREQ-1:0] rdy_o,
    output logic            gnt_vld_o,
    output logic            gnt_idx_o
);
    arb_e state_q, state_d;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= ARB_OPEN;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d   = ARB_OPEN;
        rdy_o     = '0;
        gnt_vld_o = 1'b0;
        gnt_idx_o = 1'b0;
        unique case (state_q)
            ARB_OPEN: begin
                rdy_o[0]  = 1'b1;
                rdy_o[1]  = !vld_i[0];
                gnt_vld_o = |vld_i;
                gnt_idx_o = !vld_i[0];
                if (vld_i[0] && vld_i[1]) state_d = ARB_OWED1;
            end
            ARB_OWED1: begin
                rdy_o[1]  = 1'b1;
                rdy_o[0]  = !vld_i[1];
                gnt_vld_o = |vld_i;
                gnt_idx_o = vld_i[1];
                state_d   = ARB_OPEN;
            end
            default: state_d = ARB_OPEN;
        endcase
    end
endmodule

// File: rtl/llsc_resv_table.sv
module llsc_resv_table
    import llsc_pkg::*;
#(
    parameter int AW = 4
)(
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          op_vld_i,
    input  logic          op_req_i,
    input  op_e           op_kind_i,
    input  logic [AW-1:0] op_addr_i,
    input  logic          wr_commit_i,
    output logic          sc_pass_o
);
    logic [NREQ-1:0] resv_vld;
    logic [AW-1:0]   resv_addr [NREQ];

    for (genvar k = 0; k < NREQ; k++) begin : g_slot
        logic          v_q;
        logic [AW-1:0] a_q;
        logic          mine;

        assign mine = op_vld_i && (int'(op_req_i) == k);

        always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
                v_q <= 1'b0;
                a_q <= '0;
            end else begin
                if (wr_commit_i && v_q && (a_q == op_addr_i)) v_q <= 1'b0;
                if (mine && op_kind_i == OP_SC)                v_q <= 1'b0;
                if (mine && op_kind_i == OP_LL) begin
                    v_q <= 1'b1;
                    a_q <= op_addr_i;
                end
            end
        end

        assign resv_vld[k]  = v_q;
        assign resv_addr[k] = a_q;
    end

    assign sc_pass_o = resv_vld[op_req_i] && (resv_addr[op_req_i] == op_addr_i);
endmodule

// File: rtl/llsc_word_mem.sv
module llsc_word_mem #(
    parameter int DW = 32,
    parameter int AW = 4
)(
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
        end else if (we_i) begin
            cells[addr_i] <= wdata_i;
        end
    end

    assign rdata_o = cells[addr_i];
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
    import llsc_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 4
)(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [1:0]       req_vld_i,
    output logic [1:0]       req_rdy_o,
    input  logic [3:0]       req_op_i,
    input  logic [2*AW-1:0]  req_addr_i,
    input  logic [2*DW-1:0]  req_wdata_i,
    output logic [1:0]       rsp_vld_o,
    output logic [2*DW-1:0]  rsp_data_o,
    output logic [1:0]       rsp_flag_o
);
    logic          gnt_vld;
    logic          gnt_idx;
    op_e           sel_op;
    logic [AW-1:0] sel_addr;
    logic [DW-1:0] sel_wdata;
    logic [DW-1:0] mem_rdata;
    logic          sc_pass;
    logic          wr_commit;
    logic          is_read;

    llsc_arbiter u_arb (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .vld_i     (req_vld_i),
        .rdy_o     (req_rdy_o),
        .gnt_vld_o (gnt_vld),
        .gnt_idx_o (gnt_idx)
    );

    assign sel_op    = op_e'(req_op_i[gnt_idx*2 +: 2]);
    assign sel_addr  = req_addr_i[gnt_idx*AW +: AW];
    assign sel_wdata = req_wdata_i[gnt_idx*DW +: DW];

    assign wr_commit = gnt_vld && ((sel_op == OP_WR) || (sel_op == OP_SC && sc_pass));
    assign is_read   = (sel_op == OP_RD) || (sel_op == OP_LL);

    llsc_resv_table #(.AW(AW)) u_resv (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .op_vld_i    (gnt_vld),
        .op_req_i    (gnt_idx),
        .op_kind_i   (sel_op),
        .op_addr_i   (sel_addr),
        .wr_commit_i (wr_commit),
        .sc_pass_o   (sc_pass)
    );

    llsc_word_mem #(.DW(DW), .AW(AW)) u_mem (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (wr_commit),
        .addr_i  (sel_addr),
        .wdata_i (sel_wdata),
        .rdata_o (mem_rdata)
    );

    for (genvar k = 0; k < NREQ; k++) begin : g_rsp
        logic          v_q;
        logic          f_q;
        logic [DW-1:0] d_q;
        logic          hit;

        assign hit = gnt_vld && (int'(gnt_idx) == k);

        always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
                v_q <= 1'b0;
                f_q <= 1'b0;
                d_q <= '0;
            end else begin
                v_q <= hit;
                if (hit) begin
                    f_q <= (sel_op == OP_SC) && sc_pass;
                    d_q <= is_read ? mem_rdata : '0;
                end else begin
                    f_q <= 1'b0;
                end
            end
        end

        assign rsp_vld_o[k]            = v_q;
        assign rsp_flag_o[k]           = f_q;
        assign rsp_data_o[k*DW +: DW]  = d_q;
    end
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic [1:0] req_vld_i,
    input logic [1:0] req_rdy_o,
    input logic [3:0] req_op_i,
    input logic [1:0] rsp_vld_o,
    input logic [1:0] rsp_flag_o
);
    // R11: never two acceptances in one cycle
    p_single_accept_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !((req_vld_i[0] && req_rdy_o[0]) && (req_vld_i[1] && req_rdy_o[1])));

    for (genvar k = 0; k < 2; k++) begin : g_k
        // R11: a stalled requester is accepted on the next edge
        p_stall_once_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (req_vld_i[k] && !req_rdy_o[k]) |=> req_rdy_o[k]);

        // R2: acceptance is answered one cycle later
        p_rsp_follows_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (req_vld_i[k] && req_rdy_o[k]) |=> rsp_vld_o[k]);

        // R2: no response without an acceptance
        p_no_spurious_rsp_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !(req_vld_i[k] && req_rdy_o[k]) |=> !rsp_vld_o[k]);

        // R4: a set flag only answers a conditional store
        p_flag_from_sc_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
            rsp_flag_o[k] |-> (rsp_vld_o[k] && $past(req_op_i[k*2 +: 2]) == 2'd3));
    end
endmodule

bind llsc_monitor llsc_monitor_chk u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_vld_i  (req_vld_i),
    .req_rdy_o  (req_rdy_o),
    .req_op_i   (req_op_i),
    .rsp_vld_o  (rsp_vld_o),
    .rsp_flag_o (rsp_flag_o)
);

// File: tb/llsc_monitor_bench.sv
module llsc_monitor_bench;
    localparam int DW = 32;
    localparam int AW = 4;
    localparam logic [1:0] RD = 2'd0, WR = 2'd1, LL = 2'd2, SC = 2'd3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0]      vld = '0;
    logic [1:0]      rdy;
    logic [3:0]      op = '0;
    logic [2*AW-1:0] addr = '0;
    logic [2*DW-1:0] wdata = '0;
    logic [1:0]      rvld;
    logic [2*DW-1:0] rdata;
    logic [1:0]      rflag;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    llsc_monitor #(.DW(DW), .AW(AW)) u_llsc_monitor (
        .clk_i (clk), .rst_ni (rst_n),
        .req_vld_i (vld), .req_rdy_o (rdy), .req_op_i (op),
        .req_addr_i (addr), .req_wdata_i (wdata),
        .rsp_vld_o (rvld), .rsp_data_o (rdata), .rsp_flag_o (rflag)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_op(input int k, input logic [1:0] o, input int a, input logic [31:0] d,
                         output logic [31:0] rd, output logic fl);
        @(negedge clk);
        vld[k] = 1'b1;
        op[k*2 +: 2] = o;
        addr[k*AW +: AW] = a[AW-1:0];
        wdata[k*DW +: DW] = d;
        #1;
        while (!rdy[k]) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        @(negedge clk);
        vld[k] = 1'b0;
        chk("R2 response valid", 32'(rvld[k]), 32'd1);
        rd = rdata[k*DW +: DW];
        fl = rflag[k];
    endtask

    logic [31:0] r;
    logic        f;

    task automatic t_reset;
        chk("R1 no response after reset", 32'(rvld), 32'd0);
        chk("R1 both ready when idle", 32'(rdy), 32'd3);
        do_op(0, RD, 5, 0, r, f);
        chk("R1 memory cleared", r, 32'd0);
        do_op(1, SC, 5, 32'hDEAD, r, f);
        chk("R1 no reservation after reset", 32'(f), 32'd0);
    endtask

    task automatic t_rw;
        do_op(0, WR, 3, 32'h1111_2222, r, f);
        chk("R3 write flag zero", 32'(f), 32'd0);
        do_op(1, RD, 3, 0, r, f);
        chk("R3 written word read back", r, 32'h1111_2222);
        chk("R2 read flag zero", 32'(f), 32'd0);
        do_op(0, LL, 3, 0, r, f);
        chk("R2 linked read returns word", r, 32'h1111_2222);
        do_op(0, RD, 2, 0, r, f);  // leave reservation on 3 harmlessly
    endtask

    task automatic t_llsc_ok;
        do_op(0, LL, 4, 0, r, f);
        do_op(0, SC, 4, 32'hA5, r, f);
        chk("R4 conditional store succeeds", 32'(f), 32'd1);
        do_op(1, RD, 4, 0, r, f);
        chk("R4 conditional data stored", r, 32'hA5);
    endtask

    task automatic t_sc_fail;
        do_op(0, SC, 6, 32'h77, r, f);
        chk("R5 store without reservation fails", 32'(f), 32'd0);
        do_op(0, RD, 6, 0, r, f);
        chk("R5 memory unchanged", r, 32'd0);
        do_op(0, LL, 7, 0, r, f);
        do_op(0, SC, 8, 32'h88, r, f);
        chk("R5 address mismatch fails", 32'(f), 32'd0);
        do_op(1, RD, 8, 0, r, f);
        chk("R5 mismatched word unchanged", r, 32'd0);
    endtask

    task automatic t_other_write;
        do_op(0, LL, 9, 0, r, f);
        do_op(1, WR, 9, 32'h99, r, f);
        do_op(0, SC, 9, 32'h55, r, f);
        chk("R6 peer write cancels", 32'(f), 32'd0);
        do_op(0, RD, 9, 0, r, f);
        chk("R6 peer data kept", r, 32'h99);
    endtask

    task automatic t_unrelated;
        do_op(0, LL, 10, 0, r, f);
        do_op(1, WR, 11, 32'h1, r, f);
        do_op(0, WR, 2, 32'h2, r, f);
        do_op(0, SC, 10, 32'h42, r, f);
        chk("R7 reservation survives other writes", 32'(f), 32'd1);
        do_op(1, RD, 10, 0, r, f);
        chk("R7 stored", r, 32'h42);
    endtask

    task automatic t_sc_clears_own;
        do_op(0, LL, 12, 0, r, f);
        do_op(0, SC, 12, 32'h1, r, f);
        chk("R8 first store succeeds", 32'(f), 32'd1);
        do_op(0, SC, 12, 32'h2, r, f);
        chk("R8 second store fails", 32'(f), 32'd0);
        do_op(0, RD, 12, 0, r, f);
        chk("R8 word from first store", r, 32'h1);
        do_op(1, LL, 0, 0, r, f);
        do_op(1, SC, 15, 32'h3, r, f);
        do_op(1, SC, 0, 32'h4, r, f);
        chk("R8 failed store also clears", 32'(f), 32'd0);
    endtask

    task automatic t_peer;
        do_op(0, LL, 13, 0, r, f);
        do_op(1, LL, 13, 0, r, f);
        do_op(1, SC, 13, 32'hB, r, f);
        chk("R9 first store succeeds", 32'(f), 32'd1);
        do_op(0, SC, 13, 32'hA, r, f);
        chk("R9 peer reservation cancelled", 32'(f), 32'd0);
        do_op(0, RD, 13, 0, r, f);
        chk("R9 winner data kept", r, 32'hB);
    endtask

    task automatic t_ll_over;
        do_op(0, LL, 14, 0, r, f);
        do_op(0, LL, 15, 0, r, f);
        do_op(0, SC, 14, 32'h3, r, f);
        chk("R10 old address fails", 32'(f), 32'd0);
        do_op(0, LL, 14, 0, r, f);
        do_op(0, LL, 15, 0, r, f);
        do_op(0, SC, 15, 32'h5, r, f);
        chk("R10 newest address succeeds", 32'(f), 32'd1);
        do_op(1, RD, 14, 0, r, f);
        chk("R10 old word untouched", r, 32'd0);
    endtask

    task automatic t_own_write;
        do_op(1, LL, 1, 0, r, f);
        do_op(1, WR, 1, 32'h5, r, f);
        do_op(1, SC, 1, 32'h6, r, f);
        chk("R12 own write cancels", 32'(f), 32'd0);
        do_op(1, RD, 1, 0, r, f);
        chk("R12 plain data kept", r, 32'h5);
    endtask

    task automatic t_arb;
        @(negedge clk);
        vld = 2'b11;
        op = {RD, RD};
        addr = {4'd3, 4'd4};
        #1;
        chk("R11 requester 0 ready on contention", 32'(rdy[0]), 32'd1);
        chk("R11 requester 1 stalled", 32'(rdy[1]), 32'd0);
        @(posedge clk);
        @(negedge clk);
        addr[0 +: AW] = 4'd12;
        #1;
        chk("R11 requester 0 answered", rdata[0 +: DW], 32'hA5);
        chk("R11 owed turn ready 1", 32'(rdy[1]), 32'd1);
        chk("R11 owed turn holds 0", 32'(rdy[0]), 32'd0);
        @(posedge clk);
        @(negedge clk);
        vld[1] = 1'b0;
        #1;
        chk("R11 requester 1 answered", rdata[DW +: DW], 32'h1111_2222);
        chk("R11 only 1 answered", 32'(rvld), 32'd2);
        chk("R11 back to open", 32'(rdy[0]), 32'd1);
        @(posedge clk);
        @(negedge clk);
        vld[0] = 1'b0;
        chk("R11 held request served", rdata[0 +: DW], 32'h1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_rw();
        t_llsc_ok();
        t_sc_fail();
        t_other_write();
        t_unrelated();
        t_sc_clears_own();
        t_peer();
        t_ll_over();
        t_own_write();
        t_arb();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule